// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Read Path

This block is the load side of a 32 KB level-one data cache. It splits each 32-bit virtual address into a page number and a 13-bit page offset. It selects a cache set using bits of the offset alone. The offset is identical in the virtual and the physical address, so the four ways of the selected set are read while a small on-block translation buffer turns the 19-bit virtual page number into a 15-bit physical page number.

The stored tag of each line is the full physical page number. It is compared against the translation in every way at once, and the matching way steers a 32-bit word out through a multiplexer. Two virtual pages mapped to one physical page therefore find the same line, so no duplicate copies can appear.

The translation buffer and the lines are loaded through two fill ports, and both choose their victim with a per-set round-robin pointer. Every request gets a response one cycle later: hit with data, miss, or fault.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `rsp_valid` is 0, and every line and translation entry is empty. A request before any translation fill answers fault; with a translation but no line fill, it answers miss.
- R2: A response appears in the cycle after each request (`req_valid` high at one edge gives `rsp_valid` high after the next edge), and only then. With `rsp_valid` high, exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is 1.
- R3: Translation uses the virtual page number `req_vaddr[31:13]`. The translation set is bit 13 of the address (bit 0 of the page number), with 2 sets of 8 ways. A page number absent from the translation buffer answers fault.
- R4: The permission field is `tlb_fill_perm` with bit 0 = readable, bit 1 = writable, bit 2 = executable, bit 3 = kernel-only. An access answers fault when the readable bit is 0, or when the kernel-only bit is 1 and `req_kernel` is 0. A fault is never reported as a hit.
- R5: The cache set index is `req_vaddr[12:5]`, and the line tag is the 15-bit physical page number. A hit occurs when a valid way of that set holds the translated page number. It returns word k = `req_vaddr[4:2]` of the line, which is `line_fill_data[32k+31:32k]`.
- R6: When the translation succeeds but no way matches, the response is miss and `rsp_data` is 0. `rsp_data` is 0 on every non-hit response.
- R7: Each line fill writes the way pointed to by the round-robin pointer of `line_fill_set`, then advances that pointer. The fifth fill into one set replaces the line from the first fill, and other sets keep their lines.
- R8: Two virtual pages that translate to the same physical page hit the same line with the same data.
- R9: The writable and executable bits have no effect on a read response.
- R10: Each translation set has its own round-robin pointer over 8 ways. The ninth fill into a set replaces its first entry, and the tenth fill replaces its second. Entries of the other set are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_kernel | input | 1 | Request made with kernel privilege |
| tlb_fill_valid | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | 19 | Virtual page number of the new entry |
| tlb_fill_ppn | input | 15 | Physical page number of the new entry |
| tlb_fill_perm | input | 4 | Permission bits of the new entry |
| line_fill_valid | input | 1 | Write one cache line |
| line_fill_set | input | 8 | Set receiving the line |
| line_fill_tag | input | 15 | Physical page number stored as the tag |
| line_fill_data | input | 256 | Line contents, word k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_miss | output | 1 | Translation succeeded, no way matched |
| rsp_fault | output | 1 | Translation missing or access not permitted |
| rsp_data | output | 32 | Hit word, zero otherwise |

## Verification
The hardest states to reach from the ports are the replacement wrap-arounds. The translation pointer must go all the way round its eight ways before an old mapping disappears. A cache set must take five fills before the first line is displaced. The stimulus therefore fills one translation set ten times and one cache set five times. Between fills it issues reads that prove which entries survive, and it reads a neighbouring set to show that the other set was left alone. Synonyms and permission faults are reached by mapping several virtual pages, with different permission bits, onto one physical page that already holds a line.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    parameter int VA_W       = 32;
    parameter int PA_W       = 28;
    parameter int PG_OFF     = 13;
    parameter int LN_OFF     = 5;
    parameter int CACHE_WAYS = 4;
    parameter int TLB_SETS   = 2;
    parameter int TLB_WAYS   = 8;
    parameter int WORD_W     = 32;

    localparam int VPN_W   = VA_W - PG_OFF;
    localparam int PPN_W   = PA_W - PG_OFF;
    localparam int SET_W   = PG_OFF - LN_OFF;
    localparam int SETS    = 1 << SET_W;
    localparam int LINE_W  = 8 * (1 << LN_OFF);
    localparam int WB_W    = $clog2(WORD_W / 8);
    localparam int WSEL_W  = LN_OFF - WB_W;
    localparam int WAY_W   = $clog2(CACHE_WAYS);
    localparam int TSET_W  = $clog2(TLB_SETS);
    localparam int TWAY_W  = $clog2(TLB_WAYS);

    typedef struct packed {
        logic kern;
        logic exec;
        logic wr;
        logic rd;
    } perm_t;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              miss;
        logic              fault;
        logic [WORD_W-1:0] data;
    } rsp_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
    import vipt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output perm_t            lk_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  perm_t            fill_perm
);
    logic              vld_q  [TLB_SETS][TLB_WAYS];
    logic              vld_d  [TLB_SETS][TLB_WAYS];
    logic [VPN_W-1:0]  vpn_q  [TLB_SETS][TLB_WAYS];
    logic [VPN_W-1:0]  vpn_d  [TLB_SETS][TLB_WAYS];
    logic [PPN_W-1:0]  ppn_q  [TLB_SETS][TLB_WAYS];
    logic [PPN_W-1:0]  ppn_d  [TLB_SETS][TLB_WAYS];
    perm_t             perm_q [TLB_SETS][TLB_WAYS];
    perm_t             perm_d [TLB_SETS][TLB_WAYS];
    logic [TWAY_W-1:0] rr_q   [TLB_SETS];
    logic [TWAY_W-1:0] rr_d   [TLB_SETS];

    logic [TSET_W-1:0] lset;
    logic [TSET_W-1:0] fset;
    assign lset = lk_vpn[TSET_W-1:0];
    assign fset = fill_vpn[TSET_W-1:0];

    // next-state: write the victim way and bump the set's pointer
    always_comb begin
        vld_d  = vld_q;
        vpn_d  = vpn_q;
        ppn_d  = ppn_q;
        perm_d = perm_q;
        rr_d   = rr_q;
        if (fill_en) begin
            vld_d[fset][rr_q[fset]]  = 1'b1;
            vpn_d[fset][rr_q[fset]]  = fill_vpn;
            ppn_d[fset][rr_q[fset]]  = fill_ppn;
            perm_d[fset][rr_q[fset]] = fill_perm;
            rr_d[fset]               = rr_q[fset] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '{default: '0};
            rr_q  <= '{default: '0};
        end else begin
            vld_q  <= vld_d;
            vpn_q  <= vpn_d;
            ppn_q  <= ppn_d;
            perm_q <= perm_d;
            rr_q   <= rr_d;
        end
    end

    // associative lookup across every way of the selected set
    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int w = 0; w < TLB_WAYS; w++) begin
            if (vld_q[lset][w] && vpn_q[lset][w] == lk_vpn) begin
                lk_hit  = 1'b1;
                lk_ppn  = ppn_q[lset][w];
                lk_perm = perm_q[lset][w];
            end
        end
    end

    // R10: a fill advances only its own set's pointer by one
    p_tlb_rr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> rr_q[$past(fset)] == TWAY_W'($past(rr_q[fset]) + 1));

    // R3: the filled entry is valid in the following cycle
    p_tlb_fill_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fset)][$past(rr_q[fset])]);
endmodule

// File: rtl/vipt_ways.sv
module vipt_ways
    import vipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WSEL_W-1:0] rd_wsel,
    input  logic [PPN_W-1:0]  cmp_ppn,
    output logic              any_hit,
    output logic [WORD_W-1:0] hit_word,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [PPN_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);
    logic             vld_q [SETS][CACHE_WAYS];
    logic             vld_d [SETS][CACHE_WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];
    logic [WAY_W-1:0] rr_d  [SETS];
    logic [WAY_W-1:0] fill_way;

    logic [CACHE_WAYS-1:0] way_hit;
    logic [WORD_W-1:0]     way_word [CACHE_WAYS];

    assign fill_way = rr_q[fill_set];

    always_comb begin
        vld_d = vld_q;
        rr_d  = rr_q;
        if (fill_en) begin
            vld_d[fill_set][fill_way] = 1'b1;
            rr_d[fill_set]            = fill_way + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '{default: '0};
            rr_q  <= '{default: '0};
        end else begin
            vld_q <= vld_d;
            rr_q  <= rr_d;
        end
    end

    // one tag and data store per way, all read in parallel
    for (genvar w = 0; w < CACHE_WAYS; w++) begin : g_way
        logic [LINE_W-1:0] mem_q [SETS];
        logic [PPN_W-1:0]  tag_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_W'(w)) begin
                mem_q[fill_set] <= fill_line;
                tag_q[fill_set] <= fill_tag;
            end
        end

        assign way_word[w] = mem_q[rd_set][rd_wsel*WORD_W +: WORD_W];
        assign way_hit[w]  = vld_q[rd_set][w] && (tag_q[rd_set] == cmp_ppn);
    end

    // comparator outputs steer the word multiplexer
    always_comb begin
        hit_word = '0;
        for (int w = 0; w < CACHE_WAYS; w++) begin
            if (way_hit[w]) hit_word = hit_word | way_word[w];
        end
    end
    assign any_hit = |way_hit;

    // R7: the victim way of a fill is valid afterwards
    p_line_fill_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]);

    // R7: the pointer of the filled set moves on by one way
    p_line_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> rr_q[$past(fill_set)] == WAY_W'($past(fill_way) + 1));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_kernel,
    input  logic                 tlb_fill_valid,
    input  logic [VPN_W-1:0]     tlb_fill_vpn,
    input  logic [PPN_W-1:0]     tlb_fill_ppn,
    input  logic [3:0]           tlb_fill_perm,
    input  logic                 line_fill_valid,
    input  logic [SET_W-1:0]     line_fill_set,
    input  logic [PPN_W-1:0]     line_fill_tag,
    input  logic [LINE_W-1:0]    line_fill_data,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_fault,
    output logic [WORD_W-1:0]    rsp_data
);
    logic [VPN_W-1:0]  vpn;
    logic [SET_W-1:0]  cset;
    logic [WSEL_W-1:0] wsel;
    logic              tr_hit;
    logic [PPN_W-1:0]  tr_ppn;
    perm_t             tr_perm;
    logic              any_hit;
    logic [WORD_W-1:0] hit_word;
    logic              allowed;
    logic              unused_bits;
    rsp_t              rsp_d, rsp_q;

    // page number goes to translation, page offset straight to the arrays
    assign vpn  = req_vaddr[VA_W-1:PG_OFF];
    assign cset = req_vaddr[PG_OFF-1:LN_OFF];
    assign wsel = req_vaddr[LN_OFF-1:WB_W];
    assign unused_bits = ^{req_vaddr[WB_W-1:0], tr_perm.wr, tr_perm.exec};

    vipt_tlb u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (vpn),
        .lk_hit    (tr_hit),
        .lk_ppn    (tr_ppn),
        .lk_perm   (tr_perm),
        .fill_en   (tlb_fill_valid),
        .fill_vpn  (tlb_fill_vpn),
        .fill_ppn  (tlb_fill_ppn),
        .fill_perm (perm_t'(tlb_fill_perm))
    );

    vipt_ways u_ways (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (cset),
        .rd_wsel   (wsel),
        .cmp_ppn   (tr_ppn),
        .any_hit   (any_hit),
        .hit_word  (hit_word),
        .fill_en   (line_fill_valid),
        .fill_set  (line_fill_set),
        .fill_tag  (line_fill_tag),
        .fill_line (line_fill_data)
    );

    assign allowed = tr_hit && tr_perm.rd && (!tr_perm.kern || req_kernel);

    always_comb begin
        rsp_d       = '0;
        rsp_d.vld   = req_valid;
        if (req_valid) begin
            rsp_d.fault = !allowed;
            rsp_d.hit   = allowed && any_hit;
            rsp_d.miss  = allowed && !any_hit;
            rsp_d.data  = (allowed && any_hit) ? hit_word : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_fault = rsp_q.fault;
    assign rsp_data  = rsp_q.data;

    // R2: a request yields a response exactly one cycle later
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: exactly one outcome flag per response
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

    // R4: a fault never carries a hit
    p_fault_not_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !rsp_hit);

    // R6: non-hit responses carry zero data
    p_nohit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_data == '0);
endmodule

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
    localparam int CLK_PERIOD = 10;
    localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         req_kernel = 1'b0;
    logic         tlb_fill_valid = 1'b0;
    logic [18:0]  tlb_fill_vpn = '0;
    logic [14:0]  tlb_fill_ppn = '0;
    logic [3:0]   tlb_fill_perm = '0;
    logic         line_fill_valid = 1'b0;
    logic [7:0]   line_fill_set = '0;
    logic [14:0]  line_fill_tag = '0;
    logic [255:0] line_fill_data = '0;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0]  rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int          q_kind [$];
    logic [31:0] q_data [$];
    string       q_name [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kernel(req_kernel), .tlb_fill_valid(tlb_fill_valid),
        .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
        .tlb_fill_perm(tlb_fill_perm), .line_fill_valid(line_fill_valid),
        .line_fill_set(line_fill_set), .line_fill_tag(line_fill_tag),
        .line_fill_data(line_fill_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] word_of(input logic [7:0] seed, input logic [14:0] tag, input int k);
        return {seed, 1'b0, tag, 8'(k)};
    endfunction

    function automatic logic [255:0] line_of(input logic [7:0] seed, input logic [14:0] tag);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = word_of(seed, tag, k);
        return l;
    endfunction

    function automatic logic [31:0] va(input logic [18:0] vpn, input logic [7:0] set, input int k);
        return {vpn, set, 3'(k), 2'b00};
    endfunction

    task automatic quiet();
        req_valid = 1'b0; tlb_fill_valid = 1'b0; line_fill_valid = 1'b0;
    endtask

    task automatic tlb_fill(input logic [18:0] vpn, input logic [14:0] ppn, input logic [3:0] perm);
        @(negedge clk);
        quiet();
        tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn; tlb_fill_perm = perm;
    endtask

    task automatic line_fill(input logic [7:0] set, input logic [14:0] tag, input logic [7:0] seed);
        @(negedge clk);
        quiet();
        line_fill_valid = 1'b1; line_fill_set = set; line_fill_tag = tag;
        line_fill_data = line_of(seed, tag);
    endtask

    // driver: issue a read and push what the requirements predict
    task automatic rd(input logic [31:0] addr, input logic kern, input int kind,
                      input logic [31:0] data, input string name);
        @(negedge clk);
        quiet();
        req_valid = 1'b1; req_vaddr = addr; req_kernel = kern;
        q_kind.push_back(kind);
        q_data.push_back(kind == K_HIT ? data : 32'h0);
        q_name.push_back(name);
    endtask

    // monitor: compare each response against the queue head
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            checks++;
            if (q_kind.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected response: actual valid=1 expected none");
            end else begin
                int k; logic [31:0] d; string n;
                int got;
                k = q_kind.pop_front(); d = q_data.pop_front(); n = q_name.pop_front();
                got = rsp_hit ? K_HIT : rsp_miss ? K_MISS : rsp_fault ? K_FAULT : -1;
                if (got != k || rsp_data != d || (rsp_hit + rsp_miss + rsp_fault) != 1) begin
                    fails++;
                    $display("FAIL %s: actual h/m/f=%0b%0b%0b data=%h expected kind=%0d data=%h",
                             n, rsp_hit, rsp_miss, rsp_fault, rsp_data, k, d);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [18:0] A = 19'h00010, B = 19'h00022, C = 19'h00031, D = 19'h00033, E = 19'h00040;
    localparam logic [14:0] P = 15'h0123;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++; $display("FAIL R1 reset: actual rsp_valid=%b expected 0", rsp_valid);
        end
        @(negedge clk); rst_n = 1'b1;

        rd(va(A, 8'h05, 1), 1'b0, K_FAULT, 0, "R1 R3 no translation");
        tlb_fill(A, P, 4'b0001);
        rd(va(A, 8'h05, 1), 1'b0, K_MISS, 0, "R1 R6 empty line");
        line_fill(8'h05, P, 8'h11);
        rd(va(A, 8'h05, 1), 1'b0, K_HIT, word_of(8'h11, P, 1), "R5 word1");
        rd(va(A, 8'h05, 7), 1'b0, K_HIT, word_of(8'h11, P, 7), "R5 word7");
        rd(va(A, 8'h07, 0), 1'b0, K_MISS, 0, "R6 other set");
        line_fill(8'h06, P, 8'h22);
        rd(va(A, 8'h06, 2), 1'b0, K_HIT, word_of(8'h22, P, 2), "R5 set6");

        tlb_fill(B, P, 4'b0111);
        rd(va(B, 8'h05, 3), 1'b0, K_HIT, word_of(8'h11, P, 3), "R8 R9 synonym");
        tlb_fill(C, P, 4'b0110);
        rd(va(C, 8'h05, 3), 1'b1, K_FAULT, 0, "R4 not readable");
        tlb_fill(D, P, 4'b1001);
        rd(va(D, 8'h05, 3), 1'b0, K_FAULT, 0, "R4 kernel-only user");
        rd(va(D, 8'h05, 3), 1'b1, K_HIT, word_of(8'h11, P, 3), "R4 kernel-only kernel");

        tlb_fill(E, 15'h0200, 4'b0001);
        line_fill(8'h05, 15'h0200, 8'h30);
        line_fill(8'h05, 15'h0201, 8'h31);
        line_fill(8'h05, 15'h0202, 8'h32);
        rd(va(A, 8'h05, 4), 1'b0, K_HIT, word_of(8'h11, P, 4), "R7 four ways held");
        rd(va(E, 8'h05, 4), 1'b0, K_HIT, word_of(8'h30, 15'h0200, 4), "R7 second way");
        line_fill(8'h05, 15'h0203, 8'h33);
        rd(va(A, 8'h05, 4), 1'b0, K_MISS, 0, "R7 fifth fill evicts first");
        rd(va(E, 8'h05, 5), 1'b0, K_HIT, word_of(8'h30, 15'h0200, 5), "R7 survivor");
        rd(va(A, 8'h06, 6), 1'b0, K_HIT, word_of(8'h22, P, 6), "R7 other set kept");

        for (int i = 0; i < 6; i++) tlb_fill(19'h00101 + 19'(2*i), P, 4'b0001);
        rd(va(D, 8'h06, 0), 1'b1, K_HIT, word_of(8'h22, P, 0), "R10 full set keeps entries");
        tlb_fill(19'h00111, P, 4'b0001);
        tlb_fill(19'h00113, P, 4'b0001);
        rd(va(D, 8'h06, 0), 1'b1, K_FAULT, 0, "R10 tenth fill evicts second");
        rd(va(19'h00111, 8'h06, 1), 1'b0, K_HIT, word_of(8'h22, P, 1), "R10 new entry");
        rd(va(19'h0010B, 8'h06, 2), 1'b0, K_HIT, word_of(8'h22, P, 2), "R10 last way kept");
        rd(va(A, 8'h06, 3), 1'b0, K_HIT, word_of(8'h22, P, 3), "R10 other set kept");

        @(negedge clk); quiet();
        repeat (3) @(negedge clk);
        checks++;
        if (q_kind.size() != 0) begin
            fails++;
            $display("FAIL R2 missing responses: actual pending=%0d expected 0", q_kind.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule